// File: doc/BRIEF.md
# Parallel 3x3 Stencil Window Streamer

This block takes an image as a stream of beats in raster order. Each beat carries P adjacent pixels of one row. Two earlier rows are kept in an internal line store that holds one entry per beat column. For every beat step, the block forms P overlapping 3x3 neighbourhoods and passes each one to its own processing element. It then emits P result pixels as one output beat. The input and output interfaces are identical, so stages of the same kind can be placed back to back to form a multi-pass filter pipeline, with no round trip through external memory.

The built-in processing element forms the sum of the nine window pixels, shifts it right by three and clips it to the pixel range. Positions on the outermost row or column copy the centre pixel unchanged, so each output frame has the same size as its input frame.

Output beat j appears one row plus one beat after input beat j. After the last beat of a frame, the block produces the remaining outputs by itself by stepping through internal flush beats, and it refuses input while it does so. Image width, image height, pixel width and P are parameters. The width must be a multiple of P, and the height must be at least 2.

Top module: `stencil_stream`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: When the block waits for the first beat of a frame, an accepted beat with in_sof low is discarded: it produces no output and does not disturb the next frame.
- R3: Pixel i of a beat occupies bits [i*DW +: DW] and is column b*P+i, where b is the beat index within its row. Each input frame of IMG_H rows by IMG_W/P beats produces exactly that many output beats, in the same raster order. The outputs for the final row are emitted with no further input.
- R4: For an interior position (r,c), the output is the sum of the nine input pixels at rows r-1..r+1 and columns c-1..c+1, shifted right by 3 and clipped to 2^DW-1.
- R5: For a position on row 0, row IMG_H-1, column 0 or column IMG_W-1, the output equals the input pixel at that position.
- R6: While out_valid is high and out_ready is low, out_data and the markers stay unchanged and in_ready is low. Stalls on either side never lose or repeat a pixel.
- R7: out_sof is high only on the first beat of an output frame, and out_eol is high only on the last beat of each output row. in_eol must be high only on the last beat of an input row.
- R8: Idle cycles on the input (in_valid low) do not change any output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat |
| in_sof | input | 1 | Input beat is the first beat of a frame |
| in_eol | input | 1 | Input beat is the last beat of a row |
| in_data | input | P*DW | P input pixels, pixel i at bits [i*DW +: DW] |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_sof | output | 1 | Output beat is the first beat of a frame |
| out_eol | output | 1 | Output beat is the last beat of a row |
| out_data | output | P*DW | P result pixels, same layout as in_data |

## Verification
The hardest situation to reach is the tail of a frame. There the block runs internal flush beats while the consumer is stalling, and the windows that straddle a beat seam take neighbours from three different registers. The stimulus runs whole frames under several ready and valid gap patterns, so that flush beats coincide with backpressure. It uses saturating and alternating pixel patterns, so that a wrong seam neighbour or a lost clip changes the result. A directed case sends unframed beats ahead of a frame to show that they leave no trace.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
    // right shift applied to the nine-pixel sum
    localparam int WIN_SHIFT = 3;
    // number of pixels in one neighbourhood
    localparam int WIN_TAPS  = 9;
    // guard bits to hold the sum of nine pixels
    localparam int SUM_GUARD = 4;
endpackage

// File: rtl/stencil_lnbuf.sv
module stencil_lnbuf #(
    parameter int DEPTH = 4,
    parameter int WID   = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  rd_addr,
    output logic [WID-1:0] rd_data,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [WID-1:0] wr_data
);
    logic [WID-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // R3
    rdwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_addr != $past(wr_addr)) || (rd_data == $past(wr_data)));
endmodule

// File: rtl/stencil_pe.sv
module stencil_pe
    import stencil_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [WIN_TAPS*DW-1:0] win,
    input  logic                   border,
    output logic [DW-1:0]          px
);
    localparam int SW = DW + SUM_GUARD;
    localparam logic [SW-1:0] MAXV = SW'((1 << DW) - 1);

    logic [SW-1:0] sum_d;
    logic [SW-1:0] avg_d;

    always_comb begin
        sum_d = '0;
        for (int t = 0; t < WIN_TAPS; t++) begin
            sum_d = sum_d + SW'(win[t*DW +: DW]);
        end
        avg_d = sum_d >> WIN_SHIFT;
        if (border) begin
            px = win[4*DW +: DW];
        end else if (avg_d > MAXV) begin
            px = MAXV[DW-1:0];
        end else begin
            px = avg_d[DW-1:0];
        end
    end
endmodule

// File: rtl/stencil_stream.sv
module stencil_stream
    import stencil_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 4,
    parameter int P     = 4,
    parameter int DW    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            in_sof,
    input  logic            in_eol,
    input  logic [P*DW-1:0] in_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic            out_sof,
    output logic            out_eol,
    output logic [P*DW-1:0] out_data
);
    localparam int NB  = IMG_W / P;
    localparam int BXW = (NB > 1) ? $clog2(NB) : 1;
    localparam int RW  = $clog2(IMG_H + 2);
    localparam int BW  = P * DW;

    typedef struct packed {
        logic [BXW-1:0] bx;
        logic [RW-1:0]  ry;
        logic [BXW-1:0] ox;
        logic [RW-1:0]  oy;
        logic [BW-1:0]  c1t;
        logic [BW-1:0]  c1m;
        logic [BW-1:0]  c1b;
        logic [DW-1:0]  c2t;
        logic [DW-1:0]  c2m;
        logic [DW-1:0]  c2b;
        logic           ov;
        logic           osof;
        logic           oeol;
        logic [BW-1:0]  od;
    } st_t;

    st_t s_d, s_q;

    logic           flushing, can_adv, accept, drop, step, emit;
    logic [BW-1:0]  newpix, rtop, rmid;
    logic [2*BW-1:0] rd_word;
    logic [BW-1:0]  res;

    assign flushing = (s_q.ry >= RW'(IMG_H));
    assign can_adv  = !s_q.ov || out_ready;
    assign in_ready = can_adv && !flushing;
    assign accept   = in_valid && in_ready;
    assign drop     = accept && (s_q.ry == '0) && (s_q.bx == '0) && !in_sof;
    assign step     = (accept && !drop) || (flushing && can_adv);
    assign emit     = step && ((s_q.ry >= RW'(2)) || ((s_q.ry == RW'(1)) && (s_q.bx != '0)));
    assign newpix   = flushing ? '0 : in_data;
    assign rtop     = rd_word[2*BW-1:BW];
    assign rmid     = rd_word[BW-1:0];

    stencil_lnbuf #(.DEPTH(NB), .WID(2*BW)) lnbuf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (s_q.bx),
        .rd_data (rd_word),
        .wr_en   (step),
        .wr_addr (s_q.bx),
        .wr_data ({rmid, newpix})
    );

    for (genvar g = 0; g < P; g++) begin : g_pe
        logic [DW-1:0] lt, lm, lb, rt, rm, rb;
        logic          edge_b;
        if (g == 0) begin : g_left_seam
            assign lt = s_q.c2t;
            assign lm = s_q.c2m;
            assign lb = s_q.c2b;
        end else begin : g_left_in
            assign lt = s_q.c1t[(g-1)*DW +: DW];
            assign lm = s_q.c1m[(g-1)*DW +: DW];
            assign lb = s_q.c1b[(g-1)*DW +: DW];
        end
        if (g == P-1) begin : g_right_seam
            assign rt = rtop[0 +: DW];
            assign rm = rmid[0 +: DW];
            assign rb = newpix[0 +: DW];
        end else begin : g_right_in
            assign rt = s_q.c1t[(g+1)*DW +: DW];
            assign rm = s_q.c1m[(g+1)*DW +: DW];
            assign rb = s_q.c1b[(g+1)*DW +: DW];
        end
        assign edge_b = (s_q.oy == '0) || (s_q.oy == RW'(IMG_H-1)) ||
                        ((s_q.ox == '0) && (g == 0)) ||
                        ((s_q.ox == BXW'(NB-1)) && (g == P-1));
        stencil_pe #(.DW(DW)) pe_i (
            .win    ({rb, s_q.c1b[g*DW +: DW], lb,
                      rm, s_q.c1m[g*DW +: DW], lm,
                      rt, s_q.c1t[g*DW +: DW], lt}),
            .border (edge_b),
            .px     (res[g*DW +: DW])
        );
    end

    always_comb begin
        s_d = s_q;
        if (step) begin
            if (s_q.ry == RW'(IMG_H+1)) begin
                s_d.bx = '0;
                s_d.ry = '0;
            end else if (s_q.bx == BXW'(NB-1)) begin
                s_d.bx = '0;
                s_d.ry = s_q.ry + RW'(1);
            end else begin
                s_d.bx = s_q.bx + BXW'(1);
            end
            s_d.c2t = s_q.c1t[(P-1)*DW +: DW];
            s_d.c2m = s_q.c1m[(P-1)*DW +: DW];
            s_d.c2b = s_q.c1b[(P-1)*DW +: DW];
            s_d.c1t = rtop;
            s_d.c1m = rmid;
            s_d.c1b = newpix;
        end
        if (emit) begin
            s_d.ov   = 1'b1;
            s_d.od   = res;
            s_d.osof = (s_q.ox == '0) && (s_q.oy == '0);
            s_d.oeol = (s_q.ox == BXW'(NB-1));
            if (s_q.ox == BXW'(NB-1)) begin
                s_d.ox = '0;
                s_d.oy = (s_q.oy == RW'(IMG_H-1)) ? '0 : s_q.oy + RW'(1);
            end else begin
                s_d.ox = s_q.ox + BXW'(1);
            end
        end else if (out_ready) begin
            s_d.ov = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.ov;
    assign out_sof   = s_q.osof;
    assign out_eol   = s_q.oeol;
    assign out_data  = s_q.od;

    // R6
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                    $stable(out_sof) && $stable(out_eol));
    // R6
    stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
    // R6
    out_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_ready));
    // R7
    in_eol_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_eol |-> (s_q.bx == BXW'(NB-1)));
endmodule

// File: tb/stencil_stream_tb.sv
module stencil_stream_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int H  = 4;
    localparam int P  = 4;
    localparam int DW = 8;
    localparam int NB = W / P;
    localparam int MAXV = (1 << DW) - 1;
    localparam int NVEC = 6;
    // {pattern[5:4], stall mode[3:2], gap mode[1:0]}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b00_00_00, 6'b01_00_00, 6'b10_01_00,
        6'b11_00_01, 6'b01_10_10, 6'b10_01_01
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [P*DW-1:0] in_data = '0;
    logic in_ready, out_valid, out_sof, out_eol;
    logic out_ready = 1'b0;
    logic [P*DW-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int fr [H][W];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stencil_stream #(.IMG_W(W), .IMG_H(H), .P(P), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
        .in_eol(in_eol), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof),
        .out_eol(out_eol), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic fill(input int pat);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                case (pat)
                    0: fr[r][c] = (r*7 + c*13) & MAXV;
                    1: fr[r][c] = MAXV;
                    2: fr[r][c] = ((r ^ c) & 1) ? MAXV : 0;
                    default: fr[r][c] = ((r*W + c)*37 + 11) & MAXV;
                endcase
    endtask

    function automatic int expect_px(input int r, input int c);
        int s = 0;
        if (r == 0 || r == H-1 || c == 0 || c == W-1) return fr[r][c];
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
                s += fr[r+dr][c+dc];
        s = s >> 3;
        return (s > MAXV) ? MAXV : s;
    endfunction

    function automatic bit gap_now(input int mode);
        case (mode)
            1: return (cyc % 2) == 0;
            2: return (cyc % 7) < 3;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit rdy_now(input int mode);
        case (mode)
            1: return (cyc % 3) != 0;
            2: return (cyc % 5) < 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic send_beat(input logic [P*DW-1:0] d, input logic sof, input logic eol,
                             input int gmode);
        @(negedge clk);
        while (gap_now(gmode)) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b1; in_data = d; in_sof = sof; in_eol = eol;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic drive(input int gmode, input int junk);
        logic [P*DW-1:0] d;
        for (int j = 0; j < junk; j++) send_beat('1, 1'b0, 1'b0, gmode);
        for (int r = 0; r < H; r++)
            for (int b = 0; b < NB; b++) begin
                for (int i = 0; i < P; i++) d[i*DW +: DW] = DW'(fr[r][b*P+i]);
                send_beat(d, (r == 0 && b == 0), (b == NB-1), gmode);
            end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    endtask

    task automatic consume(input int smode);
        int got = 0;
        int wait_cnt = 0;
        bit held = 1'b0;
        logic [P*DW-1:0] hd = '0;
        while (got < H*NB && wait_cnt < 3000) begin
            @(negedge clk);
            out_ready = rdy_now(smode);
            #1;
            wait_cnt++;
            if (held) begin
                // R6 stalled beat must still be offered unchanged
                check(out_valid && out_data == hd, "R6 hold", int'(out_data[DW-1:0]), int'(hd[DW-1:0]));
            end
            held = 1'b0;
            if (out_valid && out_ready) begin
                int r = got / NB;
                int b = got % NB;
                for (int i = 0; i < P; i++) begin
                    int c = b*P + i;
                    int e = expect_px(r, c);
                    int a = int'(out_data[i*DW +: DW]);
                    if (r == 0 || r == H-1 || c == 0 || c == W-1)
                        check(a == e, "R5 border", a, e);
                    else
                        check(a == e, "R4 interior", a, e);
                end
                // R7 frame and row markers
                check(out_sof == (got == 0), "R7 sof", int'(out_sof), int'(got == 0));
                check(out_eol == (b == NB-1), "R7 eol", int'(out_eol), int'(b == NB-1));
                got++;
            end else if (out_valid) begin
                held = 1'b1;
                hd = out_data;
            end
        end
        // R3 complete frame, tail produced without further input
        check(got == H*NB, "R3 beat count", got, H*NB);
        @(negedge clk);
        out_ready = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        rst_n = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            fill(int'(VEC[v][5:4]));
            fork
                drive(int'(VEC[v][1:0]), 0);
                consume(int'(VEC[v][3:2]));
            join
        end
        // R2 unframed beats ahead of a frame leave no trace
        fill(3);
        fork
            drive(0, 2);
            consume(0);
        join
        // R8 heavy idle gaps on input with free output
        fill(0);
        fork
            drive(2, 0);
            consume(0);
        join
        repeat (4) @(negedge clk);
        #1;
        // R3 back to idle after flush
        check(out_valid == 1'b0, "R3 idle out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R3 idle in_ready", int'(in_ready), 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule